// File: doc/BRIEF.md
# Parallel-Lane Programmable Coarse Delay

This block delays a wideband sample stream by a number of sample periods chosen at run time. The stream arrives as several lanes per clock, one sample per lane, with the lowest-numbered lane holding the earliest sample of the word. Each lane owns a circular buffer that is written on every clock. The programmed delay has two parts. The upper bits choose how many whole words back each buffer is read, plus a one-word correction on lanes whose samples wrap into the previous word. The lower bits rotate samples across output lanes, so a delay that is not a multiple of the lane count is still exact.

A new delay value is taken from the delay input only on a rising edge of the sync input, and only while the load enable is high. It applies from the word carrying that sync edge onward. The sync input travels through a pipeline that matches the data path, so sync_out marks the first output word that uses the new delay. The stream is continuous: one word enters and one word leaves on every clock. There is no valid or ready signal and no back-pressure, because the buffers are written on every cycle.

Top module: `lane_coarse_delay`

## Requirements
- R1: While reset is asserted, and for the first 4 clock edges after it is released, lanes_out is all zero and sync_out is low.
- R2: Let input word t be the word sampled on the t-th clock edge after reset (t from 0), and let sample number 4t+k be its lane k (bits 8k+7:8k). Output lane k of the word that leaves 4 cycles after word t equals sample 4t+k-D, where D is the delay in effect for word t.
- R3: With D=2, the sample on input lane 1 appears on output lane 3 of the same output word, and input lanes 2 and 3 move to output lanes 0 and 1 of the next word.
- R4: Delays that are not a multiple of 4 (for example 1, 3 and 5) follow R2 exactly. Lanes whose source sample lies in an earlier word read one word further back.
- R5: The delay in effect is loaded from delay_in when sync_in is high after being low (or high on the first edge after reset) and load_en is high. If sync_in stays high, no further load happens.
- R6: A sync_in rising edge with load_en low leaves the delay in effect unchanged.
- R7: A newly loaded delay applies from the word that carries the sync_in edge onward, which is the output word marked by sync_out.
- R8: sync_out equals sync_in delayed by exactly 4 clock cycles.
- R9: An output sample whose source sample number (from R2) is negative, meaning it was never written since reset, reads as zero.
- R10: The maximum delay of 2047 samples follows R2, using every one of the 512 buffer entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Sync marker. Its rising edge can load a new delay |
| load_en | input | 1 | Allows a sync rising edge to load delay_in |
| delay_in | input | 11 | Requested delay in samples |
| lanes_in | input | 32 | Four 8-bit input samples, lane k at bits 8k+7:8k |
| sync_out | output | 1 | Sync aligned with the delayed data |
| lanes_out | output | 32 | Four 8-bit delayed samples, same lane layout |

## Verification
On every cycle, the assertions check the sync pipeline alignment, the quiet output after reset, the rule that the delay register loads only on an enabled sync rising edge and holds at all other times, and that the fill count never decreases and never exceeds the buffer depth. The exact sample mapping cannot be checked by an assertion. This covers the per-lane carry, the lane rotation, the zero output before the buffer holds the needed data, and the switch-over at the sync boundary. Only the bench's directed scenarios show these, by comparing each output word against a sample-number model for delays 0, 1, 2, 3, 5 and 2047 and across delay changes.

// File: rtl/cdl_pkg.sv
package cdl_pkg;
  // output lane dst takes its sample from this buffer lane after rotation by sel
  function automatic int src_lane(input int dst, input int sel, input int lanes);
    return (dst + lanes - sel) % lanes;
  endfunction

  // a buffer lane whose samples fall into the previous word reads one word further back
  function automatic logic wraps_back(input int lane, input int sel, input int lanes);
    return (lane + sel) >= lanes;
  endfunction
endpackage

// File: rtl/cdl_lane_buf.sv
module cdl_lane_buf #(
  parameter int SAMPLE_W = 8,
  parameter int DEPTH    = 512,
  parameter int RD_LAT   = 3,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [ADDR_W:0]     back_words,
  input  logic [ADDR_W:0]     fill_cnt,
  input  logic [SAMPLE_W-1:0] din,
  output logic [SAMPLE_W-1:0] dout
);
  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [SAMPLE_W-1:0] pipe [RD_LAT];
  logic [ADDR_W-1:0]   rd_addr;
  logic                avail;
  logic                bypass;

  assign rd_addr = wr_addr - back_words[ADDR_W-1:0];
  assign bypass  = (back_words == '0);
  assign avail   = (back_words <= fill_cnt);

  always_ff @(posedge clk) begin
    mem[wr_addr] <= din;
  end

  // read happens before the write to the same entry, so a full-depth offset reads the oldest word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RD_LAT; i++) pipe[i] <= '0;
    end else begin
      if (!avail)      pipe[0] <= '0;
      else if (bypass) pipe[0] <= din;
      else             pipe[0] <= mem[rd_addr];
      for (int i = 1; i < RD_LAT; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[RD_LAT-1];
endmodule

// File: rtl/cdl_lane_rot.sv
module cdl_lane_rot #(
  parameter int LANES    = 4,
  parameter int SAMPLE_W = 8,
  localparam int SEL_W   = $clog2(LANES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SEL_W-1:0]          sel,
  input  logic [LANES*SAMPLE_W-1:0] din,
  output logic [LANES*SAMPLE_W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
    end else begin
      for (int k = 0; k < LANES; k++)
        dout[k*SAMPLE_W +: SAMPLE_W] <=
          din[cdl_pkg::src_lane(k, int'(sel), LANES)*SAMPLE_W +: SAMPLE_W];
    end
  end
endmodule

// File: rtl/cdl_ctrl.sv
module cdl_ctrl #(
  parameter int LANES     = 4,
  parameter int MAX_DELAY = 2048,
  parameter int RD_LAT    = 3,
  localparam int DLY_W    = $clog2(MAX_DELAY),
  localparam int SEL_W    = $clog2(LANES),
  localparam int DEPTH    = MAX_DELAY / LANES,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int LAT      = RD_LAT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_in,
  input  logic              load_en,
  input  logic [DLY_W-1:0]  delay_in,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W:0]   fill_cnt,
  output logic [ADDR_W-1:0] word_off,
  output logic [SEL_W-1:0]  sel_now,
  output logic [SEL_W-1:0]  sel_rot,
  output logic [DLY_W-1:0]  dly_act,
  output logic              sync_out
);
  logic             sync_q;
  logic             take;
  logic [DLY_W-1:0] dly_use;
  logic [LAT-1:0]   sync_pipe;
  logic [SEL_W-1:0] sel_pipe [RD_LAT];

  assign take     = sync_in & ~sync_q & load_en;
  assign dly_use  = take ? delay_in : dly_act;
  assign word_off = dly_use[DLY_W-1:SEL_W];
  assign sel_now  = dly_use[SEL_W-1:0];
  assign sel_rot  = sel_pipe[RD_LAT-1];
  assign sync_out = sync_pipe[LAT-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= 1'b0;
      dly_act   <= '0;
      wr_addr   <= '0;
      fill_cnt  <= '0;
      sync_pipe <= '0;
      for (int i = 0; i < RD_LAT; i++) sel_pipe[i] <= '0;
    end else begin
      sync_q    <= sync_in;
      wr_addr   <= wr_addr + 1'b1;
      sync_pipe <= {sync_pipe[LAT-2:0], sync_in};
      if (take) dly_act <= delay_in;
      if (fill_cnt != (ADDR_W+1)'(DEPTH)) fill_cnt <= fill_cnt + 1'b1;
      sel_pipe[0] <= sel_now;
      for (int i = 1; i < RD_LAT; i++) sel_pipe[i] <= sel_pipe[i-1];
    end
  end
endmodule

// File: rtl/lane_coarse_delay.sv
module lane_coarse_delay #(
  parameter int LANES     = 4,
  parameter int SAMPLE_W  = 8,
  parameter int MAX_DELAY = 2048,
  parameter int RD_LAT    = 3,
  localparam int DLY_W    = $clog2(MAX_DELAY),
  localparam int SEL_W    = $clog2(LANES),
  localparam int DEPTH    = MAX_DELAY / LANES,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int BUS_W    = LANES * SAMPLE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic             load_en,
  input  logic [DLY_W-1:0] delay_in,
  input  logic [BUS_W-1:0] lanes_in,
  output logic             sync_out,
  output logic [BUS_W-1:0] lanes_out
);
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W:0]   fill_cnt;
  logic [ADDR_W-1:0] word_off;
  logic [SEL_W-1:0]  sel_now;
  logic [SEL_W-1:0]  sel_rot;
  logic [DLY_W-1:0]  dly_act;
  logic [BUS_W-1:0]  buf_out;

  cdl_ctrl #(.LANES(LANES), .MAX_DELAY(MAX_DELAY), .RD_LAT(RD_LAT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .load_en(load_en),
    .delay_in(delay_in), .wr_addr(wr_addr), .fill_cnt(fill_cnt),
    .word_off(word_off), .sel_now(sel_now), .sel_rot(sel_rot),
    .dly_act(dly_act), .sync_out(sync_out)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic            wrap;
    logic [ADDR_W:0] back;
    assign wrap = cdl_pkg::wraps_back(j, int'(sel_now), LANES);
    assign back = {1'b0, word_off} + {{ADDR_W{1'b0}}, wrap};
    cdl_lane_buf #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH), .RD_LAT(RD_LAT)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .back_words(back),
      .fill_cnt(fill_cnt), .din(lanes_in[j*SAMPLE_W +: SAMPLE_W]),
      .dout(buf_out[j*SAMPLE_W +: SAMPLE_W])
    );
  end

  cdl_lane_rot #(.LANES(LANES), .SAMPLE_W(SAMPLE_W)) u_rot (
    .clk(clk), .rst_n(rst_n), .sel(sel_rot), .din(buf_out), .dout(lanes_out)
  );
endmodule

// File: rtl/cdl_checker.sv
module cdl_checker #(
  parameter int LANES     = 4,
  parameter int SAMPLE_W  = 8,
  parameter int MAX_DELAY = 2048,
  parameter int RD_LAT    = 3,
  localparam int DLY_W    = $clog2(MAX_DELAY),
  localparam int DEPTH    = MAX_DELAY / LANES,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int LAT      = RD_LAT + 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      sync_in,
  input logic                      load_en,
  input logic [DLY_W-1:0]          delay_in,
  input logic                      sync_out,
  input logic [LANES*SAMPLE_W-1:0] lanes_out,
  input logic [DLY_W-1:0]          dly_act,
  input logic [ADDR_W:0]           fill_cnt
);
  logic [3:0] since;
  logic       prev_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since     <= '0;
      prev_sync <= 1'b0;
    end else begin
      prev_sync <= sync_in;
      if (since != 4'hF) since <= since + 1'b1;
    end
  end

  // R8
  sync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(since) >= LAT) |-> (sync_out == $past(sync_in, LAT)));

  // R1
  quiet_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(since) < LAT) |-> (lanes_out == '0 && !sync_out));

  // R5
  delay_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in && !prev_sync && load_en) |=> (dly_act == $past(delay_in)));

  // R6
  delay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_in || prev_sync || !load_en) |=> $stable(dly_act));

  // R9
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill_cnt) <= DEPTH);

  // R9
  fill_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fill_cnt >= $past(fill_cnt)));
endmodule

bind lane_coarse_delay cdl_checker #(
  .LANES(LANES), .SAMPLE_W(SAMPLE_W), .MAX_DELAY(MAX_DELAY), .RD_LAT(RD_LAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .load_en(load_en),
  .delay_in(delay_in), .sync_out(sync_out), .lanes_out(lanes_out),
  .dly_act(dly_act), .fill_cnt(fill_cnt)
);

// File: tb/lane_coarse_delay_bench.sv
module lane_coarse_delay_bench;
  localparam int LANES = 4;
  localparam int SW    = 8;
  localparam int DLY_W = 11;
  localparam int LAT   = 4;
  localparam int HIST  = 1024;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sync_in = 1'b0;
  logic             load_en = 1'b0;
  logic [DLY_W-1:0] delay_in = '0;
  logic [31:0]      lanes_in = '0;
  logic             sync_out;
  logic [31:0]      lanes_out;

  int total = 0;
  int bad   = 0;
  int t     = 0;
  logic [DLY_W-1:0] act = '0;
  logic             ps  = 1'b0;
  logic [DLY_W-1:0] dly_hist [HIST];
  logic             sync_hist [HIST];

  always #2 clk = ~clk;

  lane_coarse_delay u_lane_coarse_delay (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .load_en(load_en),
    .delay_in(delay_in), .lanes_in(lanes_in), .sync_out(sync_out),
    .lanes_out(lanes_out)
  );

  task automatic check_word(input string tag);
    int w;
    int n;
    logic [31:0] exp;
    logic        exp_sync;
    string       use_tag;
    w = t - LAT;
    exp = '0;
    exp_sync = 1'b0;
    use_tag = tag;
    for (int k = 0; k < LANES; k++) begin
      n = (w >= 0) ? (4*w + k - int'(dly_hist[w])) : -1;
      if (n < 0) use_tag = "R9";
      else exp[k*SW +: SW] = 8'(n);
    end
    if (w >= 0) exp_sync = sync_hist[w];
    total++;
    if (lanes_out !== exp) begin
      bad++;
      $display("FAIL %s word %0d lanes actual=%h expected=%h", use_tag, w, lanes_out, exp);
    end
    total++;
    if (sync_out !== exp_sync) begin
      bad++;
      $display("FAIL R8 word %0d sync_out actual=%b expected=%b", w, sync_out, exp_sync);
    end
  endtask

  // called at a falling edge: checks the output, then drives word t
  task automatic step(input logic s, input logic e, input logic [DLY_W-1:0] d, input string tag);
    check_word(tag);
    sync_in  = s;
    load_en  = e;
    delay_in = d;
    for (int k = 0; k < LANES; k++) lanes_in[k*SW +: SW] = 8'(4*t + k);
    if (s && !ps && e) act = d;
    ps = s;
    if (t < HIST) begin
      dly_hist[t]  = act;
      sync_hist[t] = s;
      t++;
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sync_in = 1'b0;
    load_en = 1'b0;
    delay_in = '0;
    lanes_in = '0;
    repeat (3) @(negedge clk);
    total++;
    if (lanes_out !== '0 || sync_out !== 1'b0) begin
      bad++;
      $display("FAIL R1 in reset actual=%h/%b expected=0/0", lanes_out, sync_out);
    end
    rst_n = 1'b1;
    t = 0;
    act = '0;
    ps = 1'b0;
  endtask

  task automatic run_fixed(input logic [DLY_W-1:0] d, input string tag, input int nwords);
    do_reset();
    step(1'b1, 1'b1, d, tag);
    for (int i = 0; i < nwords; i++) step(1'b0, 1'b1, d, tag);
  endtask

  task automatic run_no_load();
    do_reset();
    step(1'b1, 1'b1, 11'd3, "R6");
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 11'd3, "R6");
    step(1'b1, 1'b0, 11'd9, "R6");
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 11'd9, "R6");
  endtask

  task automatic run_held_sync();
    do_reset();
    step(1'b1, 1'b1, 11'd5, "R5");
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 11'd7, "R5");
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 11'd7, "R5");
  endtask

  task automatic run_change();
    do_reset();
    step(1'b1, 1'b1, 11'd1, "R7");
    for (int i = 0; i < 30; i++) step(1'b0, 1'b1, 11'd1, "R7");
    step(1'b1, 1'b1, 11'd6, "R7");
    for (int i = 0; i < 30; i++) step(1'b0, 1'b1, 11'd6, "R7");
    step(1'b1, 1'b1, 11'd2, "R7");
    for (int i = 0; i < 30; i++) step(1'b0, 1'b1, 11'd2, "R7");
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    run_fixed(11'd0, "R2", 40);
    run_fixed(11'd1, "R4", 40);
    run_fixed(11'd2, "R3", 40);
    run_fixed(11'd3, "R4", 40);
    run_fixed(11'd5, "R2", 40);
    run_fixed(11'd2047, "R10", 540);
    run_no_load();
    run_held_sync();
    run_change();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule